// File: doc/BRIEF.md
# Conditional Near Branch Resolver

This block resolves a conditional near jump with a signed displacement. Each request arrives as a one-cycle strobe. It carries the four-bit condition code taken from the low nibble of the opcode, five arithmetic flags, the current instruction pointer, the displacement, a protected-mode indicator and the scaled limit of the code segment.

One cycle after the strobe, the block reports whether the condition held and gives the resulting instruction pointer. A taken branch whose target fits the segment commits the new pointer and asks the fetch unit to flush its prefetch queue. In protected mode, a taken branch whose target lies above the limit raises a general-protection fault instead. In that case the pointer stays where it was.

A branch that is not taken raises a one-cycle "not taken" event and keeps the old pointer. Decode, fetch, flag generation and delivery of the fault are handled elsewhere.

Top module: `bcu_branch_resolve`

## Requirements
- R1: While rst_ni is low and until the first strobe, every output is zero.
- R2: done_o pulses high for exactly the cycle after each valid_i cycle, and all results appear in that same cycle. taken_o, flush_o, gp_fault_o and not_taken_o are low whenever done_o is low.
- R3: The even condition codes test the following: 0 tests OF, 2 tests CF, 4 tests ZF, 6 tests (CF or ZF), 8 tests SF, 10 tests PF, 12 tests (SF xor OF), and 14 tests ZF or (SF xor OF). taken_o reports the result.
- R4: Each odd code 2k+1 yields the inverse of the even code 2k.
- R5: The target is ip_i plus the sign-extended displacement, taken modulo 2^32. When a taken branch commits, new_ip_o equals the target and flush_o is high.
- R6: When the condition is false, new_ip_o equals ip_i, not_taken_o is high, and flush_o and gp_fault_o are low.
- R7: When prot_i is high and a taken branch's target is strictly greater than cs_limit_i, gp_fault_o is high, flush_o is low and new_ip_o equals ip_i.
- R8: A target equal to cs_limit_i does not fault.
- R9: When prot_i is low, no limit check is made and a taken branch always commits.
- R10: fault_code_o is always zero.
- R11: new_ip_o holds its value in cycles that follow no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One-cycle request strobe |
| cc_i | input | 4 | Condition code (opcode low nibble) |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag |
| ip_i | input | 32 | Current instruction pointer |
| disp_i | input | 32 | Signed displacement |
| prot_i | input | 1 | Protected mode active |
| cs_limit_i | input | 32 | Scaled code-segment limit |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Condition held |
| new_ip_o | output | 32 | Resulting instruction pointer |
| flush_o | output | 1 | Prefetch flush request |
| gp_fault_o | output | 1 | General-protection fault |
| fault_code_o | output | 16 | Fault error code (zero) |
| not_taken_o | output | 1 | Not-taken event pulse |

## Verification
The assertions check on every cycle that result pulses appear only after a strobe, and that a flush and a fault are never raised together. They also check that a flush always comes with a taken branch, that a fault implies protected mode, that a not-taken result keeps the sampled pointer, and that the pointer holds across idle cycles.

The correctness of each of the sixteen conditions over all flag combinations can only be shown by the bench's scenarios. The same holds for the exact target arithmetic, including wraparound and negative displacements, and for the boundary where the target equals the limit.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic cf_f;
    logic pf_f;
  } flags_t;

  // cc[3:1] selects the base test; cc[0] inverts it
  typedef enum logic [2:0] {
    BASE_OVF  = 3'd0,
    BASE_CARRY = 3'd1,
    BASE_ZERO = 3'd2,
    BASE_BELOW_EQ = 3'd3,
    BASE_SIGN = 3'd4,
    BASE_PARITY = 3'd5,
    BASE_LESS = 3'd6,
    BASE_LESS_EQ = 3'd7
  } cond_base_e;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int CC_W = 4
) (
  input  logic [CC_W-1:0] cc_i,
  input  flags_t          flags_i,
  output logic            cond_o
);
  cond_base_e base;
  logic       raw;
  logic       lt;

  assign base = cond_base_e'(cc_i[3:1]);
  assign lt   = flags_i.sf_f ^ flags_i.of_f;

  always_comb begin
    unique case (base)
      BASE_OVF:      raw = flags_i.of_f;
      BASE_CARRY:    raw = flags_i.cf_f;
      BASE_ZERO:     raw = flags_i.zf_f;
      BASE_BELOW_EQ: raw = flags_i.cf_f | flags_i.zf_f;
      BASE_SIGN:     raw = flags_i.sf_f;
      BASE_PARITY:   raw = flags_i.pf_f;
      BASE_LESS:     raw = lt;
      BASE_LESS_EQ:  raw = flags_i.zf_f | lt;
      default:       raw = 1'b0;
    endcase
  end

  assign cond_o = raw ^ cc_i[0];
endmodule

// File: rtl/bcu_target_calc.sv
module bcu_target_calc #(
  parameter int IP_W   = 32,
  parameter int DISP_W = 32
) (
  input  logic [IP_W-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              prot_i,
  input  logic [IP_W-1:0]   limit_i,
  output logic [IP_W-1:0]   target_o,
  output logic              over_o
);
  logic [IP_W-1:0] disp_ext;

  generate
    if (DISP_W < IP_W) begin : g_sext
      assign disp_ext = {{(IP_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_full
      assign disp_ext = disp_i[IP_W-1:0];
    end
  endgenerate

  assign target_o = ip_i + disp_ext;  // wraps modulo 2^IP_W
  assign over_o   = prot_i & (target_o > limit_i);
endmodule

// File: rtl/bcu_branch_resolve.sv
module bcu_branch_resolve
  import bcu_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int DISP_W = 32,
  parameter int CC_W   = 4,
  parameter int FC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  input  logic              pf_i,
  input  logic [IP_W-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              prot_i,
  input  logic [IP_W-1:0]   cs_limit_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [IP_W-1:0]   new_ip_o,
  output logic              flush_o,
  output logic              gp_fault_o,
  output logic [FC_W-1:0]   fault_code_o,
  output logic              not_taken_o
);
  flags_t          flags;
  logic            cond;
  logic [IP_W-1:0] target;
  logic            over;
  logic            fault_d;
  logic            commit_d;

  assign flags = '{of_f: of_i, sf_f: sf_i, zf_f: zf_i, cf_f: cf_i, pf_f: pf_i};

  bcu_cond_eval #(.CC_W(CC_W)) u_cond (
    .cc_i   (cc_i),
    .flags_i(flags),
    .cond_o (cond)
  );

  bcu_target_calc #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
    .ip_i    (ip_i),
    .disp_i  (disp_i),
    .prot_i  (prot_i),
    .limit_i (cs_limit_i),
    .target_o(target),
    .over_o  (over)
  );

  assign fault_d  = cond & over;
  assign commit_d = cond & ~over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      taken_o     <= 1'b0;
      flush_o     <= 1'b0;
      gp_fault_o  <= 1'b0;
      not_taken_o <= 1'b0;
      new_ip_o    <= '0;
    end else begin
      done_o      <= valid_i;
      taken_o     <= valid_i & cond;
      flush_o     <= valid_i & commit_d;
      gp_fault_o  <= valid_i & fault_d;
      not_taken_o <= valid_i & ~cond;
      if (valid_i) new_ip_o <= commit_d ? target : ip_i;
    end
  end

  assign fault_code_o = '0;

  // R2
  pulse_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o | not_taken_o | flush_o | gp_fault_o) |-> done_o);
  // R7
  flush_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_o && gp_fault_o));
  // R5
  flush_needs_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> taken_o);
  // R9
  fault_needs_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> $past(prot_i));
  // R6
  not_taken_keeps_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_taken_o |-> (new_ip_o == $past(ip_i)) && !taken_o);
  // R11
  idle_hold_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(new_ip_o));
endmodule

// File: tb/bcu_branch_resolve_bench.sv
module bcu_branch_resolve_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [3:0]  cc_i;
  logic        cf_i, zf_i, sf_i, of_i, pf_i;
  logic [31:0] ip_i, disp_i, cs_limit_i;
  logic        prot_i;
  logic        done_o, taken_o, flush_o, gp_fault_o, not_taken_o;
  logic [31:0] new_ip_o;
  logic [15:0] fault_code_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bcu_branch_resolve u_bcu_branch_resolve (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .cc_i(cc_i),
    .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i), .of_i(of_i), .pf_i(pf_i),
    .ip_i(ip_i), .disp_i(disp_i), .prot_i(prot_i), .cs_limit_i(cs_limit_i),
    .done_o(done_o), .taken_o(taken_o), .new_ip_o(new_ip_o), .flush_o(flush_o),
    .gp_fault_o(gp_fault_o), .fault_code_o(fault_code_o), .not_taken_o(not_taken_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flags: {of,sf,zf,cf,pf}
  function automatic logic ref_cond(input logic [3:0] cc, input logic [4:0] f);
    logic o, s, z, c, p;
    {o, s, z, c, p} = f;
    case (cc)
      4'd0:  return o;
      4'd1:  return !o;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return z;
      4'd5:  return !z;
      4'd6:  return c || z;
      4'd7:  return !c && !z;
      4'd8:  return s;
      4'd9:  return !s;
      4'd10: return p;
      4'd11: return !p;
      4'd12: return s != o;
      4'd13: return s == o;
      4'd14: return z || (s != o);
      default: return (s == o) && !z;
    endcase
  endfunction

  task automatic apply(input string tag, input logic [3:0] cc, input logic [4:0] f,
                       input logic [31:0] ip, input logic [31:0] disp,
                       input logic prot, input logic [31:0] lim);
    logic c, flt;
    logic [31:0] tgt, nip;
    @(negedge clk);
    {of_i, sf_i, zf_i, cf_i, pf_i} = f;
    cc_i = cc; ip_i = ip; disp_i = disp; prot_i = prot; cs_limit_i = lim;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    c   = ref_cond(cc, f);
    tgt = ip + disp;
    flt = c && prot && (tgt > lim);
    nip = (c && !flt) ? tgt : ip;
    chk({tag, " R2 done"}, 32'(done_o), 32'd1);
    chk({tag, " R3/R4 taken"}, 32'(taken_o), 32'(c));
    chk({tag, " R5 new_ip"}, new_ip_o, nip);
    chk({tag, " R5 flush"}, 32'(flush_o), 32'(c && !flt));
    chk({tag, " R7 gp_fault"}, 32'(gp_fault_o), 32'(flt));
    chk({tag, " R6 not_taken"}, 32'(not_taken_o), 32'(!c));
    chk({tag, " R10 fault_code"}, 32'(fault_code_o), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done_o), 0);
    chk("R1 taken", 32'(taken_o), 0);
    chk("R1 new_ip", new_ip_o, 0);
    chk("R1 flush", 32'(flush_o), 0);
    chk("R1 gp_fault", 32'(gp_fault_o), 0);
    chk("R1 not_taken", 32'(not_taken_o), 0);
  endtask

  task automatic t_cond_sweep();
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 32; f++)
        apply("R3 R4 sweep", 4'(cc), 5'(f), 32'h0000_1000 + 32'(cc * 32 + f), 32'h40, 1'b0, 32'h0);
  endtask

  task automatic t_arith();
    apply("R5 wrap", 4'd4, 5'b00100, 32'hFFFF_FFF0, 32'h20, 1'b0, 0);
    apply("R5 negative", 4'd5, 5'b00000, 32'h0000_0100, 32'hFFFF_FF00, 1'b0, 0);
    apply("R5 negative wrap", 4'd2, 5'b00010, 32'h10, 32'hFFFF_FF80, 1'b0, 0);
    chk("R5 wrap value", new_ip_o, 32'hFFFF_FF90);
  endtask

  task automatic t_limit();
    apply("R7 over limit", 4'd4, 5'b00100, 32'h0FF0, 32'h20, 1'b1, 32'h1000);
    chk("R7 ip kept", new_ip_o, 32'h0FF0);
    apply("R8 at limit", 4'd4, 5'b00100, 32'h0FF0, 32'h10, 1'b1, 32'h1000);
    chk("R8 committed", new_ip_o, 32'h1000);
    apply("R8 one under", 4'd7, 5'b00000, 32'h0FF0, 32'h0F, 1'b1, 32'h1000);
    apply("R7 wrap over", 4'd8, 5'b01000, 32'h10, 32'hFFFF_FFF0, 1'b1, 32'h0000_FFFF);
    apply("R9 real mode", 4'd4, 5'b00100, 32'h0FF0, 32'h100, 1'b0, 32'h1000);
    chk("R9 no fault", 32'(gp_fault_o), 0);
    apply("R6 not taken prot", 4'd5, 5'b00100, 32'h0FF0, 32'h100, 1'b1, 32'h1000);
  endtask

  task automatic t_hold();
    apply("R11 setup", 4'd0, 5'b10000, 32'h2000, 32'h444, 1'b0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ip_i = 32'hDEAD_0000 + 32'(k); disp_i = 32'h1; cc_i = 4'd1;
      chk("R11 hold new_ip", new_ip_o, 32'h2444);
      chk("R2 idle done", 32'(done_o), 0);
      chk("R2 idle pulses", 32'({taken_o, flush_o, gp_fault_o, not_taken_o}), 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; cc_i = '0;
    {cf_i, zf_i, sf_i, of_i, pf_i} = '0;
    ip_i = '0; disp_i = '0; prot_i = 1'b0; cs_limit_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cond_sweep();
    t_arith();
    t_limit();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule